// File: doc/BRIEF.md
# Local Interrupt Status Controller

This block gathers six local interrupt sources into one status register and drives one interrupt line toward the local processor. Four sources are one-cycle events: a PCI read failure, a PCI write failure, and the chain-done signals of two DMA channels. Each of these sets a bit that stays set until software clears it. The PCI interrupt source is a level. It is the OR of the upstream PCI interrupt lines that are enabled, and the status register shows that level as it is without holding it. The mailbox source is held or shown as a level, depending on a build parameter.

Software uses a small register port with one select bit. Select 0 addresses the status register and select 1 addresses the mask register. Writing 0 to a held status bit clears that bit. Setting a mask bit lets the matching status bit drive the interrupt line. The line is registered and active high.

Status and mask bit positions: 0 PCI read failure, 1 PCI write failure, 2 DMA channel 0 done, 3 DMA channel 1 done, 4 mailbox, 5 PCI interrupt.

Top module: `irq_gather`

## Requirements
- R1: A high cycle on `rd_err_evt`, `wr_err_evt`, `dma0_done` or `dma1_done` sets status bit 0, 1, 2 or 3 respectively, and the bit stays set until software clears it.
- R2: A write with `reg_sel`=0 and `reg_wr`=1 clears each held status bit whose position in `reg_wdata` is 0.
- R3: A 1 written to a held status bit changes nothing. A write to status bit 5, or to bit 4 when the mailbox is not held, is ignored.
- R4: Status bit 5 always equals the OR of `pci_lines & pci_line_en`. It follows that level in the same cycle and holds nothing.
- R5: With `MBOX_HELD`=1, bit 4 is held and is set by `mbox_req`, like R1. With `MBOX_HELD`=0, bit 4 equals `mbox_req` at all times.
- R6: `irq_o` is the OR of all status bits whose mask bit is 1. A mask bit of 0 keeps its source away from `irq_o`.
- R7: When a source event and a clearing write hit the same held bit in the same cycle, the bit ends up set.
- R8: Reset (`rst_n` low, asynchronous) clears every held status bit, every mask bit and `irq_o`.
- R9: `irq_o` is registered. It shows, one clock later, the status and mask values that were present at the clock edge.
- R10: A read with `reg_sel`=1 returns the last value written to the mask. A read with `reg_sel`=0 returns the held bits merged with the current pass-through levels. `reg_rdata` is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data of the selected register |
| rd_err_evt | input | 1 | PCI read failure event |
| wr_err_evt | input | 1 | PCI write failure event |
| dma0_done | input | 1 | DMA channel 0 chain done event |
| dma1_done | input | 1 | DMA channel 1 chain done event |
| mbox_req | input | 1 | Mailbox request, held as an event or passed through as a level |
| pci_lines | input | PCI_W | Upstream PCI interrupt lines |
| pci_line_en | input | PCI_W | Enables for the upstream PCI interrupt lines |
| irq_o | output | 1 | Registered local interrupt, active high |

## Verification
The bench builds two copies that share every input: one with `MBOX_HELD`=1 and one with `MBOX_HELD`=0, both with `PCI_W`=4. The same mailbox pulses and levels therefore show the held and the pass-through behaviour of bit 4 side by side, including a clearing write to bit 4 that only the held copy obeys. Four PCI lines with separate enables allow disabled lines to be driven high while bit 5 must stay low.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter bit MBOX_HELD = 1'b1,
  parameter int PCI_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [5:0]       reg_wdata,
  output logic [5:0]       reg_rdata,
  input  logic             rd_err_evt,
  input  logic             wr_err_evt,
  input  logic             dma0_done,
  input  logic             dma1_done,
  input  logic             mbox_req,
  input  logic [PCI_W-1:0] pci_lines,
  input  logic [PCI_W-1:0] pci_line_en,
  output logic             irq_o
);
  localparam int NSRC = 6;
  localparam int NEVT = 4;

  logic [NEVT-1:0] sticky_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] view;
  logic            mbox_bit;
  logic            pci_bit;
  logic            irq_q;

  wire             wr_stat = reg_wr & ~reg_sel;
  wire             wr_mask = reg_wr & reg_sel;
  wire [NEVT-1:0]  evt     = {dma1_done, dma0_done, wr_err_evt, rd_err_evt};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= evt | (wr_stat ? (sticky_q & reg_wdata[NEVT-1:0]) : sticky_q);

  generate
    if (MBOX_HELD) begin : g_mbox_held
      logic mbox_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) mbox_q <= 1'b0;
        else        mbox_q <= mbox_req | (wr_stat ? (mbox_q & reg_wdata[NEVT]) : mbox_q);
      assign mbox_bit = mbox_q;
    end else begin : g_mbox_level
      assign mbox_bit = mbox_req;
    end
  endgenerate

  assign pci_bit = |(pci_lines & pci_line_en);
  assign view    = {pci_bit, mbox_bit, sticky_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(view & mask_q);

  assign reg_rdata = reg_sel ? mask_q : view;
  assign irq_o     = irq_q;
endmodule

module irq_gather_chk #(
  parameter int PCI_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [5:0]       reg_wdata,
  input logic [5:0]       reg_rdata,
  input logic             rd_err_evt,
  input logic [PCI_W-1:0] pci_lines,
  input logic [PCI_W-1:0] pci_line_en,
  input logic [3:0]       sticky_q,
  input logic [5:0]       mask_q,
  input logic [5:0]       view,
  input logic             irq_o
);
  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[0] && !(reg_wr && !reg_sel && !reg_wdata[0])) |=> sticky_q[0]);

  // R3
  write_one_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[0] && !sticky_q[0] && !rd_err_evt) |=> !sticky_q[0]);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_evt |=> sticky_q[0]);

  // R4
  pci_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[5] == |(pci_lines & pci_line_en)));

  // R9
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(view) & $past(mask_q))));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (sticky_q == 4'd0 && mask_q == 6'd0 && !irq_o));
endmodule

bind irq_gather irq_gather_chk #(.PCI_W(PCI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_err_evt(rd_err_evt),
  .pci_lines(pci_lines), .pci_line_en(pci_line_en), .sticky_q(sticky_q),
  .mask_q(mask_q), .view(view), .irq_o(irq_o)
);

// File: tb/irq_gather_tb.sv
`timescale 1ns/1ps
module irq_gather_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic       rd_err_evt = 0, wr_err_evt = 0, dma0_done = 0, dma1_done = 0, mbox_req = 0;
  logic [3:0] pci_lines = '0, pci_line_en = '0;
  logic [5:0] rdata_h, rdata_l;
  logic       irq_h, irq_l;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [5:0] held_h = '0, held_l = '0, mask_m = '0;
  logic       irq_mh = 0, irq_ml = 0;

  always #2.5 clk = ~clk;

  irq_gather #(.MBOX_HELD(1'b1), .PCI_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_h), .rd_err_evt(rd_err_evt), .wr_err_evt(wr_err_evt),
    .dma0_done(dma0_done), .dma1_done(dma1_done), .mbox_req(mbox_req),
    .pci_lines(pci_lines), .pci_line_en(pci_line_en), .irq_o(irq_h));

  irq_gather #(.MBOX_HELD(1'b0), .PCI_W(4)) dut_lv (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_l), .rd_err_evt(rd_err_evt), .wr_err_evt(wr_err_evt),
    .dma0_done(dma0_done), .dma1_done(dma1_done), .mbox_req(mbox_req),
    .pci_lines(pci_lines), .pci_line_en(pci_line_en), .irq_o(irq_l));

  function automatic logic [5:0] view_h();
    return {|(pci_lines & pci_line_en), held_h[4:0]};
  endfunction
  function automatic logic [5:0] view_l();
    return {|(pci_lines & pci_line_en), mbox_req, held_l[3:0]};
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic [4:0] ev;
    @(posedge clk);
    if (!rst_n) begin
      held_h = '0; held_l = '0; mask_m = '0; irq_mh = 0; irq_ml = 0;
    end else begin
      ev = {mbox_req, dma1_done, dma0_done, wr_err_evt, rd_err_evt};
      irq_mh = |(view_h() & mask_m);
      irq_ml = |(view_l() & mask_m);
      for (int i = 0; i < 5; i++) begin
        if (ev[i]) held_h[i] = 1'b1;
        else if (reg_wr && !reg_sel && !reg_wdata[i]) held_h[i] = 1'b0;
        if (i < 4) held_l[i] = held_h[i];
      end
      if (reg_wr && reg_sel) mask_m = reg_wdata;
    end
    #2;
    check(tag, "held rdata", rdata_h, reg_sel ? mask_m : view_h());
    check(tag, "level rdata", rdata_l, reg_sel ? mask_m : view_l());
    check(tag, "held irq", irq_h, irq_mh);
    check(tag, "level irq", irq_l, irq_ml);
  endtask

  task automatic idle();
    reg_wr = 0; rd_err_evt = 0; wr_err_evt = 0; dma0_done = 0; dma1_done = 0;
  endtask

  task automatic wr(logic sel, logic [5:0] d);
    reg_sel = sel; reg_wr = 1; reg_wdata = d;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick("R8"); tick("R8");
    check("R8", "reset irq", irq_h, 0);
    check("R8", "reset status", rdata_h, 0);
    #1 rst_n = 1;
    tick("R8");

    // R1: events set held bits
    rd_err_evt = 1; dma1_done = 1; tick("R1");
    idle(); tick("R1"); tick("R1");
    check("R1", "bits 0 and 3 held", rdata_h[3:0], 4'b1001);

    // R10: mask readback
    wr(1, 6'h3F); tick("R10");
    idle(); tick("R10");
    check("R10", "mask read", rdata_h, 6'h3F);
    reg_sel = 0; tick("R9"); tick("R6");

    // R2: zero clears
    wr(0, 6'b111110); tick("R2");
    idle(); tick("R2");
    check("R2", "bit0 cleared", rdata_h[0], 0);

    // R3: ones and pass-through writes inert
    wr(0, 6'h3F); tick("R3");
    idle(); tick("R3");
    check("R3", "write ones", rdata_h[3:0], 4'b1000);

    // R4: live pci level with enables
    pci_lines = 4'b0101; pci_line_en = 4'b1010; tick("R4");
    check("R4", "disabled lines", rdata_h[5], 0);
    pci_line_en = 4'b0100; tick("R4");
    check("R4", "enabled line", rdata_h[5], 1);
    pci_lines = 4'b0; tick("R4");

    // R5: mailbox held vs level
    mbox_req = 1; tick("R5");
    mbox_req = 0; tick("R5");
    check("R5", "held mbox", rdata_h[4], 1);
    check("R5", "level mbox", rdata_l[4], 0);
    wr(0, 6'b101111); tick("R5");
    idle(); tick("R5");
    check("R5", "held mbox cleared", rdata_h[4], 0);

    // R7: set wins over clear
    dma0_done = 1; wr(0, 6'b0); tick("R7");
    idle(); tick("R7");
    check("R7", "dma0 kept", rdata_h[2], 1);

    // R6: masking
    wr(1, 6'b000010); tick("R6");
    idle(); tick("R6"); tick("R6");
    check("R6", "masked off", irq_h, 0);
    wr_err_evt = 1; tick("R6");
    idle(); tick("R9");
    check("R9", "irq rises", irq_h, 1);

    for (int n = 0; n < 3000; n++) begin
      reg_sel = $urandom_range(0, 1);
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_wdata = 6'($urandom);
      rd_err_evt = ($urandom_range(0, 9) == 0);
      wr_err_evt = ($urandom_range(0, 9) == 0);
      dma0_done = ($urandom_range(0, 9) == 0);
      dma1_done = ($urandom_range(0, 9) == 0);
      mbox_req = ($urandom_range(0, 7) == 0);
      pci_lines = 4'($urandom);
      pci_line_en = 4'($urandom);
      tick("R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule